// File: doc/BRIEF.md
# Banked Memory CRC Checker

This block listens while a byte-wide non-volatile store is copied, one bank at a time, into a cache buffer. A load strobe with a bank index opens each bank. The bank's bytes then follow on a byte stream with a valid flag, in ascending address order. Over the protected banks 1 to 5, loaded back to back in ascending order, the block builds an 8-bit CRC. The reference value is taken from inside the last protected bank.

When the last byte of bank 5 has been taken and the load order was intact, the block compares its CRC with the reference. It refreshes a status error bit and raises a one-cycle done pulse. Software can repeat the check whenever it likes by reloading banks 1 to 5 in order. If the order was broken, the status bit is left alone.

Top module: `bank_crc_checker`

## Requirements
- R1: After reset, `crc_err_o` and `check_done_o` are both 0.
- R2: The CRC is CRC-8 with polynomial 0x07 and initial value 0x00, processed MSB first. It covers every byte of banks 1 through 5 in arrival order, except byte index 8 of bank 5, which is taken as the reference. A bank holds `BANK_BYTES` bytes, 16 by default. When bank 5 completes in a valid sequence, `crc_err_o` becomes 1 if the CRC differs from the reference and 0 if it matches.
- R3: `check_done_o` is high for exactly one cycle, the cycle after the last byte of bank 5 is accepted in a valid sequence. `crc_err_o` changes only in a cycle where `check_done_o` is high.
- R4: A load of bank 1 always restarts the CRC from its initial value and starts a new valid sequence, discarding any earlier partial one.
- R5: A load whose index is not the previous bank's index plus one (bank 1 excepted) makes the sequence invalid. When bank 5 then completes, no done pulse is produced and `crc_err_o` keeps its value.
- R6: Bytes of bank 0 and of banks 6 and 7 are never included in the CRC. Loading bank 0 inside a sequence breaks it under R5, and completing a bank above 5 produces no check.
- R7: A byte is ignored if its valid flag arrives while no bank is in progress, or in the same cycle as a load strobe.
- R8: A load strobe that arrives before the current bank has received all its bytes abandons that bank. The incomplete bank breaks the sequence, even if the new index is the next one.
- R9: Checks can be repeated without limit. Each completed valid check rewrites `crc_err_o`, both from 0 to 1 and from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_load_i | input | 1 | Strobe: a bank copy into the cache starts |
| bank_idx_i | input | IDX_W (3) | Index of the bank being loaded |
| byte_valid_i | input | 1 | A byte of the current bank is on `byte_data_i` |
| byte_data_i | input | 8 | Bank byte, ascending address order |
| crc_err_o | output | 1 | 1 when the last completed check found a mismatch |
| check_done_o | output | 1 | One-cycle pulse when `crc_err_o` is refreshed |

## Verification
On every cycle, the in-line assertions check these properties:
- the done pulse lasts a single cycle;
- the error bit never moves without the done pulse;
- a bank-1 load restarts the accumulator and the sequence;
- a wrong-order load or an abandoned bank clears the sequence flag;
- stray bytes leave the byte count and the CRC untouched.

Whether the compared value is truly the CRC-8 of the right bytes can only be shown by the bench's scenarios. The same holds for whether the reference byte is skipped and for whether broken sequences leave the error bit alone. For these, a behavioural model tracks the done pulse and the error bit cycle by cycle. The scenarios cover good and corrupted images, gapped byte streams, bank 0 and upper banks, aborted banks, restarts, and bytes sent in the same cycle as a load strobe.

// File: rtl/crcchk_pkg.sv
package crcchk_pkg;

   localparam int BYTE_W = 8;

   typedef logic [BYTE_W-1:0] byte_t;

   // one MSB-first shift of a CRC register with the given polynomial
   function automatic byte_t crc_shift1(input byte_t v, input byte_t poly);
      byte_t r;
      r = {v[BYTE_W-2:0], 1'b0};
      if (v[BYTE_W-1]) r = r ^ poly;
      return r;
   endfunction

endpackage

// File: rtl/crcchk_seq.sv
module crcchk_seq #(
   parameter int BANK_BYTES = 16,
   parameter int IDX_W      = 3,
   parameter int FIRST_BANK = 1,
   parameter int LAST_BANK  = 5,
   parameter int REF_IDX    = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             valid_i,
   output logic             take_o,
   output logic             protect_o,
   output logic             ref_o,
   output logic             final_o,
   output logic             restart_o
);

   localparam int CNT_W = $clog2(BANK_BYTES + 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BANK_BYTES - 1);
   localparam logic [CNT_W-1:0] REF_CNT  = CNT_W'(REF_IDX);
   localparam logic [IDX_W-1:0] FIRST_ID = IDX_W'(FIRST_BANK);
   localparam logic [IDX_W-1:0] LAST_ID  = IDX_W'(LAST_BANK);

   logic [IDX_W-1:0] cur_q;
   logic [CNT_W-1:0] cnt_q;
   logic             active_q;
   logic             complete_q;
   logic             seq_q;
   logic [IDX_W:0]   nxt_idx;
   logic             follows;
   logic             is_first;
   logic             last_byte;

   assign nxt_idx   = {1'b0, cur_q} + (IDX_W+1)'(1);
   assign follows   = (nxt_idx == {1'b0, idx_i});
   assign is_first  = (idx_i == FIRST_ID);
   assign last_byte = (cnt_q == LAST_CNT);

   assign take_o    = valid_i && active_q && !load_i;
   assign protect_o = (cur_q >= FIRST_ID) && (cur_q <= LAST_ID);
   assign ref_o     = (cur_q == LAST_ID) && (cnt_q == REF_CNT);
   assign final_o   = take_o && last_byte && (cur_q == LAST_ID) && seq_q;
   assign restart_o = load_i && is_first;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cur_q      <= '0;
         cnt_q      <= '0;
         active_q   <= 1'b0;
         complete_q <= 1'b0;
         seq_q      <= 1'b0;
      end else if (load_i) begin
         cur_q      <= idx_i;
         cnt_q      <= '0;
         active_q   <= 1'b1;
         complete_q <= 1'b0;
         seq_q      <= is_first ? 1'b1 : (seq_q && complete_q && follows);
      end else if (take_o) begin
         if (last_byte) begin
            active_q   <= 1'b0;
            complete_q <= 1'b1;
            cnt_q      <= '0;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   // R4
   restart_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && is_first) |=> seq_q);

   // R5
   order_break_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && !is_first && !follows) |=> !seq_q);

   // R8
   abandon_break_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && !is_first && active_q) |=> !seq_q);

   // R7
   stray_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !active_q && !load_i) |=> $stable(cnt_q));

   // R2
   cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST_CNT);

endmodule

// File: rtl/crcchk_crc.sv
module crcchk_crc
   import crcchk_pkg::*;
#(
   parameter byte_t POLY = 8'h07,
   parameter byte_t INIT = 8'h00
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  clear_i,
   input  logic  en_i,
   input  byte_t data_i,
   output byte_t crc_o,
   output byte_t crc_next_o
);

   byte_t crc_q;
   byte_t stage [0:BYTE_W];

   assign stage[0] = crc_q ^ data_i;

   for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
      assign stage[g+1] = crc_shift1(stage[g], POLY);
   end

   assign crc_next_o = stage[BYTE_W];
   assign crc_o      = crc_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      crc_q <= INIT;
      else if (clear_i) crc_q <= INIT;
      else if (en_i)    crc_q <= crc_next_o;
   end

   // R4
   clear_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (crc_q == INIT));

   // R7
   hold_crc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clear_i && !en_i) |=> $stable(crc_q));

endmodule

// File: rtl/crcchk_status.sv
module crcchk_status
   import crcchk_pkg::*;
(
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  ref_we_i,
   input  byte_t data_i,
   input  logic  fire_i,
   input  byte_t calc_i,
   output logic  err_o,
   output logic  done_o
);

   byte_t ref_q;
   byte_t ref_cur;
   logic  err_q;
   logic  done_q;

   assign ref_cur = ref_we_i ? data_i : ref_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ref_q  <= '0;
         err_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= fire_i;
         if (ref_we_i) ref_q <= data_i;
         if (fire_i)   err_q <= (calc_i != ref_cur);
      end
   end

   assign err_o  = err_q;
   assign done_o = done_q;

   // R3
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q);

   // R3
   err_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(err_q) |-> done_q);

   // R3
   fire_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_i |=> done_q);

endmodule

// File: rtl/bank_crc_checker.sv
module bank_crc_checker
   import crcchk_pkg::*;
#(
   parameter int    BANK_BYTES = 16,
   parameter int    IDX_W      = 3,
   parameter int    FIRST_BANK = 1,
   parameter int    LAST_BANK  = 5,
   parameter int    REF_IDX    = 8,
   parameter byte_t POLY       = 8'h07,
   parameter byte_t INIT       = 8'h00
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             bank_load_i,
   input  logic [IDX_W-1:0] bank_idx_i,
   input  logic             byte_valid_i,
   input  logic [7:0]       byte_data_i,
   output logic             crc_err_o,
   output logic             check_done_o
);

   if (BANK_BYTES < 2) begin : g_bad_size
      $error("BANK_BYTES must be at least 2");
   end
   if (REF_IDX >= BANK_BYTES) begin : g_bad_ref
      $error("REF_IDX must lie inside a bank");
   end
   if (LAST_BANK < FIRST_BANK || FIRST_BANK < 1) begin : g_bad_range
      $error("protected bank range is empty or starts at bank 0");
   end
   if (LAST_BANK >= (1 << IDX_W)) begin : g_bad_idx
      $error("LAST_BANK does not fit in IDX_W bits");
   end

   logic  take;
   logic  protect;
   logic  is_ref;
   logic  fire;
   logic  restart;
   byte_t crc_cur;
   byte_t crc_nxt;
   byte_t calc;

   crcchk_seq #(
      .BANK_BYTES (BANK_BYTES),
      .IDX_W      (IDX_W),
      .FIRST_BANK (FIRST_BANK),
      .LAST_BANK  (LAST_BANK),
      .REF_IDX    (REF_IDX)
   ) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (bank_load_i),
      .idx_i     (bank_idx_i),
      .valid_i   (byte_valid_i),
      .take_o    (take),
      .protect_o (protect),
      .ref_o     (is_ref),
      .final_o   (fire),
      .restart_o (restart)
   );

   crcchk_crc #(
      .POLY (POLY),
      .INIT (INIT)
   ) u_crc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (restart),
      .en_i       (take && protect && !is_ref),
      .data_i     (byte_data_i),
      .crc_o      (crc_cur),
      .crc_next_o (crc_nxt)
   );

   // when the reference byte is itself the final byte, the running value is final
   assign calc = is_ref ? crc_cur : crc_nxt;

   crcchk_status u_status (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ref_we_i (take && is_ref),
      .data_i   (byte_data_i),
      .fire_i   (fire),
      .calc_i   (calc),
      .err_o    (crc_err_o),
      .done_o   (check_done_o)
   );

   // R6
   upper_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take && !protect) |=> !check_done_o);

endmodule

// File: tb/bank_crc_checker_tb.sv
module bank_crc_checker_tb;

   localparam int CLK_PERIOD = 10;
   localparam int BB  = 16;
   localparam int REF = 8;
   localparam int WD_CYCLES = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load = 1'b0;
   logic [2:0] idx = '0;
   logic       valid = 1'b0;
   logic [7:0] data = '0;
   logic       err;
   logic       done;

   int total = 0;
   int bad = 0;
   int done_seen = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bank_crc_checker u_dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .bank_load_i  (load),
      .bank_idx_i   (idx),
      .byte_valid_i (valid),
      .byte_data_i  (data),
      .crc_err_o    (err),
      .check_done_o (done)
   );

   function automatic logic [7:0] crc_of(input logic [7:0] qq[$]);
      logic [7:0] c = 8'h00;
      foreach (qq[k]) begin
         c = c ^ qq[k];
         for (int j = 0; j < 8; j++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
      end
      return c;
   endfunction

   function automatic logic [7:0] pat(input int seed, input int b, input int i);
      return 8'((seed * 37 + b * 53 + i * 11 + 5 + seed * i * 3) & 255);
   endfunction

   function automatic logic [7:0] good_crc(input int seed);
      logic [7:0] qq[$];
      for (int b = 1; b <= 5; b++)
         for (int i = 0; i < BB; i++)
            if (!(b == 5 && i == REF)) qq.push_back(pat(seed, b, i));
      return crc_of(qq);
   endfunction

   // behavioural reference model
   logic [7:0] mq[$];
   logic [7:0] mref;
   int  m_bank, m_cnt;
   bit  m_active, m_complete, m_seq;
   bit  exp_err, exp_done;

   always @(posedge clk) begin
      exp_done = 0;
      if (!rst_n) begin
         m_bank = 0; m_cnt = 0; m_active = 0; m_complete = 0; m_seq = 0;
         exp_err = 0; mref = 0; mq.delete();
      end else if (load) begin
         if (idx == 1) begin
            m_seq = 1; mq.delete();
         end else begin
            m_seq = m_seq && m_complete && (m_bank + 1 == int'(idx));
         end
         m_bank = int'(idx); m_cnt = 0; m_active = 1; m_complete = 0;
      end else if (valid && m_active) begin
         if (m_bank >= 1 && m_bank <= 5) begin
            if (m_bank == 5 && m_cnt == REF) mref = data;
            else mq.push_back(data);
         end
         if (m_cnt == BB - 1) begin
            m_active = 0; m_complete = 1;
            if (m_bank == 5 && m_seq) begin
               exp_done = 1;
               exp_err  = (crc_of(mq) != mref);
            end
         end
         m_cnt++;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (!finished) begin
         if (done === 1'b1) done_seen++;
         check("R3 done vs model", int'(done), int'(exp_done));
         check("R2 err vs model", int'(err), int'(exp_err));
      end
   end

   task automatic report;
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
   end

   task automatic idle(input int n);
      load = 0; valid = 0;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bank(input int b, input int seed, input logic [7:0] refv,
                            input int nbytes, input bit gappy, input bit junk);
      load = 1; idx = 3'(b); valid = junk; data = 8'hA5;
      @(negedge clk);
      load = 0;
      for (int i = 0; i < nbytes; i++) begin
         if (gappy && (i % 3 == 1)) begin
            valid = 0;
            @(negedge clk);
         end
         valid = 1;
         data  = (b == 5 && i == REF) ? refv : pat(seed, b, i);
         @(negedge clk);
      end
      valid = 0;
   endtask

   task automatic run_seq(input int seed, input bit corrupt, input bit gappy);
      logic [7:0] r = good_crc(seed) ^ (corrupt ? 8'h3C : 8'h00);
      for (int b = 1; b <= 5; b++) send_bank(b, seed, r, BB, gappy, 0);
      idle(2);
   endtask

   initial begin
      int d0;
      logic [7:0] r;
      repeat (3) @(negedge clk);
      // R1
      check("R1 reset err", int'(err), 0);
      check("R1 reset done", int'(done), 0);
      rst_n = 1;
      idle(2);

      // R2 matching image
      d0 = done_seen; run_seq(1, 0, 0);
      check("R2 good image err", int'(err), 0);
      check("R3 one pulse", done_seen - d0, 1);

      // R9 mismatch then match again, gapped stream
      d0 = done_seen; run_seq(2, 1, 1);
      check("R9 corrupt image err", int'(err), 1);
      check("R3 one pulse corrupt", done_seen - d0, 1);

      // R5 order 1,2,4,5
      d0 = done_seen;
      r = good_crc(7);
      send_bank(1, 7, r, BB, 0, 0); send_bank(2, 7, r, BB, 0, 0);
      send_bank(4, 7, r, BB, 0, 0); send_bank(5, 7, r, BB, 0, 0); idle(2);
      check("R5 out of order keeps err", int'(err), 1);
      check("R5 no pulse", done_seen - d0, 0);

      d0 = done_seen; run_seq(3, 0, 1);
      check("R9 clears err", int'(err), 0);
      check("R9 pulse", done_seen - d0, 1);

      // R6 bank 0 inserted, corrupted reference
      d0 = done_seen;
      r = good_crc(8) ^ 8'hFF;
      send_bank(1, 8, r, BB, 0, 0); send_bank(2, 8, r, BB, 0, 0);
      send_bank(0, 8, r, BB, 0, 0); send_bank(3, 8, r, BB, 0, 0);
      send_bank(4, 8, r, BB, 0, 0); send_bank(5, 8, r, BB, 0, 0); idle(2);
      check("R6 bank0 breaks, err kept", int'(err), 0);
      check("R6 bank0 no pulse", done_seen - d0, 0);
      d0 = done_seen;
      send_bank(6, 8, r, BB, 0, 0); send_bank(7, 8, r, BB, 0, 0); idle(2);
      check("R6 upper banks no pulse", done_seen - d0, 0);

      // R4 restart after partial sequence
      run_seq(5, 1, 0);
      check("R4 setup err", int'(err), 1);
      send_bank(1, 9, 8'h00, BB, 0, 0); send_bank(2, 9, 8'h00, 6, 0, 0);
      d0 = done_seen; run_seq(4, 0, 0);
      check("R4 restart good err", int'(err), 0);
      check("R4 restart pulse", done_seen - d0, 1);

      // R8 aborted bank 3
      d0 = done_seen;
      r = good_crc(10) ^ 8'h11;
      send_bank(1, 10, r, BB, 0, 0); send_bank(2, 10, r, BB, 0, 0);
      send_bank(3, 10, r, 5, 0, 0);  send_bank(4, 10, r, BB, 0, 0);
      send_bank(5, 10, r, BB, 0, 0); idle(2);
      check("R8 abort no pulse", done_seen - d0, 0);
      check("R8 abort err kept", int'(err), 0);
      d0 = done_seen;
      send_bank(1, 10, r, BB, 0, 0); send_bank(2, 10, r, BB, 0, 0);
      send_bank(3, 10, r, 4, 0, 0);  send_bank(3, 10, r, BB, 0, 0);
      send_bank(4, 10, r, BB, 0, 0); send_bank(5, 10, r, BB, 0, 0); idle(2);
      check("R8 reload same bank no pulse", done_seen - d0, 0);

      // R7 stray bytes and bytes on load cycles
      run_seq(11, 1, 0);
      check("R7 setup err", int'(err), 1);
      d0 = done_seen;
      r = good_crc(12);
      for (int b = 1; b <= 5; b++) begin
         send_bank(b, 12, r, BB, 0, 1);
         valid = 1; data = 8'hFF;
         repeat (3) @(negedge clk);
         valid = 0;
      end
      idle(2);
      check("R7 strays ignored err", int'(err), 0);
      check("R7 strays pulse", done_seen - d0, 1);

      idle(3);
      report();
   end

endmodule